// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits on the write side of a parallel flash bus. Each write cycle carries an address and a 16-bit data word. The block recognises unlock-prefixed command sequences of one to six writes. When a sequence completes, it raises a one-cycle command strobe. The strobe carries a decoded opcode, the address and data of the final write, and the sector and bank fields of that address.

The block also keeps the device mode: array read, autoselect, unlock bypass, secure sector, erase running and erase suspended. It accepts only the commands that are legal in the current mode. Writes that are not legal leave no trace.

An embedded-algorithm controller sits behind the strobe interface. It acts on each command and pulses a done input when an erase finishes. The decoder does not model the array, the timing of the algorithms, burst reads or a write buffer. The strobe appears in the clock cycle after the final write is sampled.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (array read) and `cmd_valid` is low. The mode encodings are array read 0, autoselect 1, unlock bypass 2, secure sector 3, erase running 4 and erase suspended 5.
- R2: The unlock addresses 555h and 2AAh are matched on the low 12 address bits only. Command bytes are matched on data bits 7:0 only.
- R3: A program command takes four writes: AA at 555h, 55 at 2AAh, A0 at 555h, then a program address with its data. The fourth write raises `cmd_valid` for one cycle in the next clock cycle. The strobe carries opcode 3, that write's address and that write's data.
- R4: An erase command takes six writes: the unlock pair, 80 at 555h, a second unlock pair, then a final write. A final 10 at 555h issues opcode 4 (chip erase). A final 30 at any address issues opcode 5 (sector erase). Either one enters mode 4. A pulse on `alg_done` in mode 4 returns the mode to 0.
- R5: The unlock pair followed by 90 at 555h issues opcode 2 and enters mode 1. In mode 1, unlock writes have no effect. A single write of F0 at any address issues opcode 1 and returns the mode to 0. F0 has the same effect in mode 0.
- R6: In mode 4, a single B0 write issues opcode 13 and enters mode 5, but only when the running erase is a sector erase. In mode 5, a single 30 write issues opcode 14 and returns the mode to 4. If `alg_done` and a B0 write arrive in the same cycle, `alg_done` wins.
- R7: The unlock pair followed by 20 at 555h issues opcode 6 and enters mode 2. In mode 2, A0 at any address followed by an address/data write issues opcode 3. 90 followed by 00 issues opcode 7 and returns the mode to 0. Any other write is ignored.
- R8: The unlock pair followed by 88 at 555h issues opcode 8 and enters mode 3. In mode 3, the unlock pair, A0 and an address/data write issue opcode 3. The unlock pair, 90 and 00 issue opcode 9 and return the mode to 0.
- R9: A single 98 at 555h issues opcode 12, but only in mode 0 or mode 1. It leaves the mode unchanged.
- R10: From mode 0, the unlock pair followed by D0 at 555h and then one more write issues opcode 10 with that write's data. The unlock pair followed by C6 at 555h issues opcode 11.
- R11: A write that does not match the next expected write of a partial sequence drops the sequence. No command is issued, and that write does not start a new sequence.
- R12: In erase suspend (mode 5), a program sequence issues opcode 3 and keeps mode 5.
- R13: With each strobe, `cmd_sector` equals address bits 21:14 and `cmd_bank` equals address bits 21:18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | A bus write cycle is present this clock |
| wr_addr | input | 22 | Write address |
| wr_data | input | 16 | Write data |
| alg_done | input | 1 | Pulse from the embedded algorithm when an erase completes |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 4 | Decoded opcode |
| cmd_addr | output | 22 | Address of the final write of the command |
| cmd_data | output | 16 | Data of the final write of the command |
| cmd_sector | output | 8 | Sector field of `cmd_addr` |
| cmd_bank | output | 4 | Bank field of `cmd_addr` |
| mode | output | 3 | Current mode |

## Verification
The hardest state to reach is erase suspend, and then behaviour inside it. Reaching it needs a full six-write sector erase, a suspend write while `alg_done` stays low, and then a program sequence or a stray resume.

The stimulus drives that whole chain. It first runs a chip erase to show that B0 is refused there. It then puts B0 and `alg_done` in the same cycle to show that completion has priority.

Broken sequences are produced by corrupting the second write of the first unlock pair, and separately the second pair inside an erase. A correct byte then follows at once to show that the breaking write started nothing.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

   typedef enum logic [3:0] {
      OP_NONE      = 4'd0,
      OP_RESET     = 4'd1,
      OP_AUTOSEL   = 4'd2,
      OP_PROGRAM   = 4'd3,
      OP_CHIP_ERS  = 4'd4,
      OP_SECT_ERS  = 4'd5,
      OP_BYP_ENTER = 4'd6,
      OP_BYP_EXIT  = 4'd7,
      OP_SEC_ENTER = 4'd8,
      OP_SEC_EXIT  = 4'd9,
      OP_CFG_SET   = 4'd10,
      OP_CFG_READ  = 4'd11,
      OP_QUERY     = 4'd12,
      OP_SUSPEND   = 4'd13,
      OP_RESUME    = 4'd14
   } op_t;

   typedef enum logic [2:0] {
      M_ARRAY   = 3'd0,
      M_AUTOSEL = 3'd1,
      M_BYPASS  = 3'd2,
      M_SECURE  = 3'd3,
      M_ERASE   = 3'd4,
      M_SUSPEND = 3'd5
   } mode_t;

   typedef enum logic [3:0] {
      S_IDLE  = 4'd0,
      S_UNL1  = 4'd1,
      S_CMD   = 4'd2,
      S_DATA  = 4'd3,
      S_CFG   = 4'd4,
      S_ERS1  = 4'd5,
      S_ERS2  = 4'd6,
      S_ERS3  = 4'd7,
      S_BYPX  = 4'd8,
      S_SECX  = 4'd9
   } seq_t;

   localparam logic [7:0] B_UNLK1  = 8'hAA;
   localparam logic [7:0] B_UNLK2  = 8'h55;
   localparam logic [7:0] B_AUTO   = 8'h90;
   localparam logic [7:0] B_PROG   = 8'hA0;
   localparam logic [7:0] B_ERSPRE = 8'h80;
   localparam logic [7:0] B_BYPASS = 8'h20;
   localparam logic [7:0] B_SECURE = 8'h88;
   localparam logic [7:0] B_CFGSET = 8'hD0;
   localparam logic [7:0] B_CFGRD  = 8'hC6;
   localparam logic [7:0] B_CHIP   = 8'h10;
   localparam logic [7:0] B_SECT   = 8'h30;
   localparam logic [7:0] B_RESET  = 8'hF0;
   localparam logic [7:0] B_SUSP   = 8'hB0;
   localparam logic [7:0] B_QUERY  = 8'h98;
   localparam logic [7:0] B_ZERO   = 8'h00;

endpackage

// File: rtl/fcd_addr_match.sv
module fcd_addr_match #(
   parameter int CW = 12
) (
   input  logic [CW-1:0] addr_lo,
   output logic          hit_555,
   output logic          hit_2aa
);

   localparam int NPAT = 2;
   localparam logic [11:0] PAT0 = 12'h555;
   localparam logic [11:0] PAT1 = 12'h2AA;

   logic [NPAT-1:0] hits;

   for (genvar i = 0; i < NPAT; i++) begin : g_pat
      localparam logic [11:0] P = (i == 0) ? PAT0 : PAT1;
      if (CW > 12) begin : g_wide
         assign hits[i] = (addr_lo == {{(CW-12){1'b0}}, P});
      end else begin : g_exact
         assign hits[i] = (addr_lo == P[CW-1:0]);
      end
   end

   assign hit_555 = hits[0];
   assign hit_2aa = hits[1];

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
   import fcd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_byte,
   input  logic       hit_555,
   input  logic       hit_2aa,
   input  logic       alg_done,
   output logic       issue,
   output op_t        issue_op,
   output mode_t      mode_q
);

   seq_t  seq_q, seq_n;
   mode_t mode_n;
   logic  sect_q, sect_n;

   always_comb begin
      seq_n    = seq_q;
      mode_n   = mode_q;
      sect_n   = sect_q;
      issue    = 1'b0;
      issue_op = OP_NONE;
      if (alg_done && mode_q == M_ERASE) begin
         mode_n = M_ARRAY;
      end
      if (wr_en) begin
         seq_n = S_IDLE;
         unique case (seq_q)
            S_IDLE: begin
               unique case (mode_q)
                  M_ARRAY, M_AUTOSEL, M_SECURE, M_SUSPEND: begin
                     if (wr_byte == B_UNLK1 && hit_555 && mode_q != M_AUTOSEL) begin
                        seq_n = S_UNL1;
                     end else if (wr_byte == B_RESET &&
                                  (mode_q == M_ARRAY || mode_q == M_AUTOSEL)) begin
                        issue = 1'b1; issue_op = OP_RESET; mode_n = M_ARRAY;
                     end else if (wr_byte == B_QUERY && hit_555 &&
                                  (mode_q == M_ARRAY || mode_q == M_AUTOSEL)) begin
                        issue = 1'b1; issue_op = OP_QUERY;
                     end else if (wr_byte == B_SECT && mode_q == M_SUSPEND) begin
                        issue = 1'b1; issue_op = OP_RESUME; mode_n = M_ERASE;
                     end
                  end
                  M_BYPASS: begin
                     if (wr_byte == B_PROG)      seq_n = S_DATA;
                     else if (wr_byte == B_AUTO) seq_n = S_BYPX;
                  end
                  M_ERASE: begin
                     if (wr_byte == B_SUSP && sect_q && !alg_done) begin
                        issue = 1'b1; issue_op = OP_SUSPEND; mode_n = M_SUSPEND;
                     end
                  end
                  default: ;
               endcase
            end
            S_UNL1: if (wr_byte == B_UNLK2 && hit_2aa) seq_n = S_CMD;
            S_CMD: begin
               if (hit_555) begin
                  unique case (mode_q)
                     M_ARRAY: begin
                        unique case (wr_byte)
                           B_AUTO:   begin issue = 1'b1; issue_op = OP_AUTOSEL;   mode_n = M_AUTOSEL; end
                           B_PROG:   seq_n = S_DATA;
                           B_ERSPRE: seq_n = S_ERS1;
                           B_BYPASS: begin issue = 1'b1; issue_op = OP_BYP_ENTER; mode_n = M_BYPASS; end
                           B_SECURE: begin issue = 1'b1; issue_op = OP_SEC_ENTER; mode_n = M_SECURE; end
                           B_CFGSET: seq_n = S_CFG;
                           B_CFGRD:  begin issue = 1'b1; issue_op = OP_CFG_READ; end
                           default: ;
                        endcase
                     end
                     M_SECURE: begin
                        if (wr_byte == B_PROG)      seq_n = S_DATA;
                        else if (wr_byte == B_AUTO) seq_n = S_SECX;
                     end
                     M_SUSPEND: if (wr_byte == B_PROG) seq_n = S_DATA;
                     default: ;
                  endcase
               end
            end
            S_DATA: begin issue = 1'b1; issue_op = OP_PROGRAM; end
            S_CFG:  begin issue = 1'b1; issue_op = OP_CFG_SET; end
            S_ERS1: if (wr_byte == B_UNLK1 && hit_555) seq_n = S_ERS2;
            S_ERS2: if (wr_byte == B_UNLK2 && hit_2aa) seq_n = S_ERS3;
            S_ERS3: begin
               if (wr_byte == B_CHIP && hit_555) begin
                  issue = 1'b1; issue_op = OP_CHIP_ERS; mode_n = M_ERASE; sect_n = 1'b0;
               end else if (wr_byte == B_SECT) begin
                  issue = 1'b1; issue_op = OP_SECT_ERS; mode_n = M_ERASE; sect_n = 1'b1;
               end
            end
            S_BYPX: if (wr_byte == B_ZERO) begin
               issue = 1'b1; issue_op = OP_BYP_EXIT; mode_n = M_ARRAY;
            end
            S_SECX: if (wr_byte == B_ZERO) begin
               issue = 1'b1; issue_op = OP_SEC_EXIT; mode_n = M_ARRAY;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q  <= S_IDLE;
         mode_q <= M_ARRAY;
         sect_q <= 1'b0;
      end else begin
         seq_q  <= seq_n;
         mode_q <= mode_n;
         sect_q <= sect_n;
      end
   end

endmodule

// File: rtl/fcd_cmd_reg.sv
module fcd_cmd_reg
   import fcd_pkg::*;
#(
   parameter int ADDR_W   = 22,
   parameter int DATA_W   = 16,
   parameter int SECT_LSB = 14,
   parameter int BANK_LSB = 18
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       issue,
   input  op_t                        issue_op,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          data,
   output logic                       cmd_valid,
   output op_t                        cmd_op,
   output logic [ADDR_W-1:0]          cmd_addr,
   output logic [DATA_W-1:0]          cmd_data,
   output logic [ADDR_W-SECT_LSB-1:0] cmd_sector,
   output logic [ADDR_W-BANK_LSB-1:0] cmd_bank
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_op    <= OP_NONE;
         cmd_addr  <= '0;
         cmd_data  <= '0;
      end else begin
         cmd_valid <= issue;
         if (issue) begin
            cmd_op   <= issue_op;
            cmd_addr <= addr;
            cmd_data <= data;
         end
      end
   end

   assign cmd_sector = cmd_addr[ADDR_W-1:SECT_LSB];
   assign cmd_bank   = cmd_addr[ADDR_W-1:BANK_LSB];

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import fcd_pkg::*;
#(
   parameter int ADDR_W      = 22,
   parameter int DATA_W      = 16,
   parameter int SECT_LSB    = 14,
   parameter int BANK_LSB    = 18,
   parameter int UNLOCK_BITS = 12,
   parameter bit FULL_MATCH  = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       alg_done,
   output logic                       cmd_valid,
   output logic [3:0]                 cmd_op,
   output logic [ADDR_W-1:0]          cmd_addr,
   output logic [DATA_W-1:0]          cmd_data,
   output logic [ADDR_W-SECT_LSB-1:0] cmd_sector,
   output logic [ADDR_W-BANK_LSB-1:0] cmd_bank,
   output logic [2:0]                 mode
);

   localparam int CW = FULL_MATCH ? ADDR_W : UNLOCK_BITS;

   if (UNLOCK_BITS < 12 || UNLOCK_BITS > ADDR_W) begin : g_bad_unlock
      $error("UNLOCK_BITS must lie between 12 and ADDR_W");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be at least 8");
   end
   if (SECT_LSB > BANK_LSB || BANK_LSB >= ADDR_W) begin : g_bad_fields
      $error("need SECT_LSB <= BANK_LSB < ADDR_W");
   end

   logic  hit_555, hit_2aa, issue;
   op_t   issue_op, op_q;
   mode_t mode_q;

   fcd_addr_match #(.CW(CW)) u_match (
      .addr_lo (wr_addr[CW-1:0]),
      .hit_555 (hit_555),
      .hit_2aa (hit_2aa)
   );

   fcd_seq_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_byte  (wr_data[7:0]),
      .hit_555  (hit_555),
      .hit_2aa  (hit_2aa),
      .alg_done (alg_done),
      .issue    (issue),
      .issue_op (issue_op),
      .mode_q   (mode_q)
   );

   fcd_cmd_reg #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SECT_LSB (SECT_LSB),
      .BANK_LSB (BANK_LSB)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (issue),
      .issue_op   (issue_op),
      .addr       (wr_addr),
      .data       (wr_data),
      .cmd_valid  (cmd_valid),
      .cmd_op     (op_q),
      .cmd_addr   (cmd_addr),
      .cmd_data   (cmd_data),
      .cmd_sector (cmd_sector),
      .cmd_bank   (cmd_bank)
   );

   assign cmd_op = op_q;
   assign mode   = mode_q;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
   import fcd_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       alg_done,
   input logic       cmd_valid,
   input logic [3:0] cmd_op,
   input logic [2:0] mode
);

   // R3: a strobe is always the answer to a write one cycle earlier
   assert_strobe_follows_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(wr_en));

   // R1: the mode never moves without a write or a completion pulse
   assert_mode_needs_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != $past(mode)) |-> ($past(wr_en) || $past(alg_done)));

   // R6: a suspend strobe only comes out of a running erase
   assert_suspend_from_erase_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_SUSPEND) |-> ($past(mode) == M_ERASE && mode == M_SUSPEND));

   // R6: leaving suspend towards erase always carries a resume strobe
   assert_resume_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == M_SUSPEND && mode == M_ERASE) |-> (cmd_valid && cmd_op == OP_RESUME));

   // R9: query strobes only in array read or autoselect
   assert_query_modes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_QUERY) |-> ($past(mode) == M_ARRAY || $past(mode) == M_AUTOSEL));

   // R5: autoselect is left only through the reset command
   assert_autosel_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == M_AUTOSEL && mode != M_AUTOSEL) |-> (cmd_valid && cmd_op == OP_RESET));

   // R4: the erase state ends through completion or suspend only
   assert_erase_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == M_ERASE && mode == M_ARRAY) |-> $past(alg_done));

endmodule

bind flash_cmd_decoder fcd_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .alg_done  (alg_done),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .mode      (mode)
);

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/100ps
module flash_cmd_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [21:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        alg_done = 1'b0;
   logic        cmd_valid;
   logic [3:0]  cmd_op;
   logic [21:0] cmd_addr;
   logic [15:0] cmd_data;
   logic [7:0]  cmd_sector;
   logic [3:0]  cmd_bank;
   logic [2:0]  mode;

   always #2.5 clk = ~clk;

   flash_cmd_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .alg_done(alg_done), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .cmd_data(cmd_data), .cmd_sector(cmd_sector), .cmd_bank(cmd_bank), .mode(mode)
   );

   int    checks = 0;
   int    fails  = 0;
   int    cycles = 0;
   bit    done_flag = 0;
   string cur_req = "R1";

   // reference model: mode and position in the current command, by number
   int m_mode = 0, m_pos = 0;
   bit m_sect = 0;
   bit e_valid = 0;
   int e_op = 0, e_addr = 0, e_data = 0;
   int q_ops[$];

   task automatic emit(int op, int a, int d);
      e_valid = 1; e_op = op; e_addr = a; e_data = d; q_ops.push_back(op);
   endtask

   task automatic model_step();
      int lo, b;
      int p;
      lo = int'(wr_addr) & 32'hFFF;
      b  = int'(wr_data) & 32'hFF;
      e_valid = 0;
      if (alg_done && m_mode == 4) m_mode = 0;
      if (!wr_en) return;
      p = m_pos;
      m_pos = 0;
      if (p == 0) begin
         if (m_mode == 2) begin
            if (b == 'hA0) m_pos = 3;
            else if (b == 'h90) m_pos = 8;
         end else if (m_mode == 4) begin
            if (b == 'hB0 && m_sect && !alg_done) begin emit(13, int'(wr_addr), int'(wr_data)); m_mode = 5; end
         end else if (b == 'hAA && lo == 'h555 && m_mode != 1) m_pos = 1;
         else if (b == 'hF0 && m_mode <= 1) begin emit(1, int'(wr_addr), int'(wr_data)); m_mode = 0; end
         else if (b == 'h98 && lo == 'h555 && m_mode <= 1) emit(12, int'(wr_addr), int'(wr_data));
         else if (b == 'h30 && m_mode == 5) begin emit(14, int'(wr_addr), int'(wr_data)); m_mode = 4; end
      end else if (p == 1) begin
         if (b == 'h55 && lo == 'h2AA) m_pos = 2;
      end else if (p == 2) begin
         if (lo == 'h555) begin
            if (m_mode == 0) begin
               case (b)
                  'h90: begin emit(2, int'(wr_addr), int'(wr_data)); m_mode = 1; end
                  'hA0: m_pos = 3;
                  'h80: m_pos = 5;
                  'h20: begin emit(6, int'(wr_addr), int'(wr_data)); m_mode = 2; end
                  'h88: begin emit(8, int'(wr_addr), int'(wr_data)); m_mode = 3; end
                  'hD0: m_pos = 4;
                  'hC6: emit(11, int'(wr_addr), int'(wr_data));
                  default: ;
               endcase
            end else if (m_mode == 3) begin
               if (b == 'hA0) m_pos = 3; else if (b == 'h90) m_pos = 9;
            end else if (m_mode == 5 && b == 'hA0) m_pos = 3;
         end
      end else if (p == 3) emit(3, int'(wr_addr), int'(wr_data));
      else if (p == 4) emit(10, int'(wr_addr), int'(wr_data));
      else if (p == 5) begin if (b == 'hAA && lo == 'h555) m_pos = 6; end
      else if (p == 6) begin if (b == 'h55 && lo == 'h2AA) m_pos = 7; end
      else if (p == 7) begin
         if (b == 'h10 && lo == 'h555) begin emit(4, int'(wr_addr), int'(wr_data)); m_mode = 4; m_sect = 0; end
         else if (b == 'h30) begin emit(5, int'(wr_addr), int'(wr_data)); m_mode = 4; m_sect = 1; end
      end else if (p == 8) begin
         if (b == 0) begin emit(7, int'(wr_addr), int'(wr_data)); m_mode = 0; end
      end else if (p == 9) begin
         if (b == 0) begin emit(9, int'(wr_addr), int'(wr_data)); m_mode = 0; end
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_pos = 0; m_sect = 0; e_valid = 0;
      end else begin
         cycles++;
         model_step();
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         checks++;
         if (cmd_valid !== e_valid || int'(mode) != m_mode ||
             (e_valid && (int'(cmd_op) != e_op || int'(cmd_addr) != e_addr ||
                          int'(cmd_data) != e_data ||
                          int'(cmd_sector) != ((e_addr >> 14) & 'hFF) ||
                          int'(cmd_bank) != ((e_addr >> 18) & 'hF)))) begin
            fails++;
            $display("FAIL %s: valid/op/mode/addr/data/sector/bank actual %0d/%0d/%0d/%h/%h/%h/%h expected %0d/%0d/%0d/%h/%h/%h/%h",
               cur_req, cmd_valid, cmd_op, mode, cmd_addr, cmd_data, cmd_sector, cmd_bank,
               e_valid, e_op, m_mode, e_addr, e_data, (e_addr >> 14) & 'hFF, (e_addr >> 18) & 'hF);
         end
      end
   end

   task automatic wr(input logic [21:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic unlock();
      wr(22'h000555, 16'h00AA);
      wr(22'h0002AA, 16'h0055);
   endtask

   task automatic pulse_done();
      alg_done = 1'b1;
      @(negedge clk);
      alg_done = 1'b0;
   endtask

   task automatic finish_run();
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      idle(3);
      // R1 reset state
      checks++;
      if (mode !== 3'd0 || cmd_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1: mode/valid actual %0d/%0d expected 0/0", mode, cmd_valid);
      end
      rst_n = 1'b1;
      idle(2);

      cur_req = "R3";
      unlock(); wr(22'h000555, 16'h00A0); wr(22'h012345, 16'hBEEF); idle(2);

      cur_req = "R2"; // upper address and data bits set on unlock writes
      wr(22'h3FF555, 16'hFFAA); wr(22'h1232AA, 16'h7755); wr(22'h2C0555, 16'h12A0);
      wr(22'h1ABCDE, 16'h5A5A); idle(2);

      cur_req = "R5";
      unlock(); wr(22'h000555, 16'h0090); idle(1);
      unlock(); wr(22'h000555, 16'h00A0); wr(22'h000100, 16'h1111);
      cur_req = "R9";
      wr(22'h000555, 16'h0098); idle(1);
      cur_req = "R5";
      wr(22'h0ABCDE, 16'h00F0); idle(1);
      wr(22'h000000, 16'h00F0); idle(1);

      cur_req = "R9";
      wr(22'h000555, 16'h0098); wr(22'h000554, 16'h0098); idle(1);

      cur_req = "R10";
      unlock(); wr(22'h000555, 16'h00D0); wr(22'h000000, 16'hC3A5); idle(1);
      unlock(); wr(22'h000555, 16'h00C6); idle(2);

      cur_req = "R7";
      unlock(); wr(22'h000555, 16'h0020);
      wr(22'h000123, 16'h00A0); wr(22'h200010, 16'h4242);
      wr(22'h000000, 16'h00A0); wr(22'h200011, 16'h4343);
      wr(22'h000555, 16'h0098); wr(22'h000000, 16'h00F0);
      wr(22'h000000, 16'h0090); wr(22'h000000, 16'h0000); idle(2);

      cur_req = "R8";
      unlock(); wr(22'h000555, 16'h0088);
      wr(22'h000000, 16'h00F0);
      unlock(); wr(22'h000555, 16'h00A0); wr(22'h000020, 16'h9876);
      unlock(); wr(22'h000555, 16'h0090); wr(22'h000000, 16'h0000); idle(2);

      cur_req = "R4";
      unlock(); wr(22'h000555, 16'h0080); unlock(); wr(22'h000555, 16'h0010); idle(1);
      cur_req = "R6"; // suspend refused during chip erase
      wr(22'h040000, 16'h00B0); idle(2);
      cur_req = "R4";
      pulse_done(); idle(1);

      cur_req = "R13";
      unlock(); wr(22'h000555, 16'h0080); unlock(); wr(22'h2A4000, 16'h0030); idle(1);
      cur_req = "R6";
      wr(22'h280000, 16'h0030); idle(1);
      wr(22'h280000, 16'h00B0); idle(1);
      cur_req = "R12";
      unlock(); wr(22'h000555, 16'h00A0); wr(22'h001000, 16'hCAFE); idle(1);
      pulse_done();
      cur_req = "R6";
      wr(22'h280000, 16'h0030); idle(1);
      // completion and suspend in the same cycle: completion wins
      alg_done = 1'b1; wr(22'h280000, 16'h00B0); alg_done = 1'b0; idle(2);

      cur_req = "R11";
      wr(22'h000555, 16'h00AA); wr(22'h0002AB, 16'h0055); wr(22'h000555, 16'h0090); idle(1);
      wr(22'h000555, 16'h00AA); wr(22'h0002AA, 16'h0054); wr(22'h0002AA, 16'h0055);
      wr(22'h000555, 16'h0090); idle(1);
      unlock(); wr(22'h000555, 16'h0080); wr(22'h000555, 16'h00AA); wr(22'h000555, 16'h0055);
      wr(22'h000555, 16'h0010); idle(2);
      unlock(); wr(22'h000555, 16'h0077); wr(22'h000555, 16'h00A0); idle(2);

      // every requirement must have produced its strobe at least once
      checks++;
      if (q_ops.size() < 20) begin
         fails++;
         $display("FAIL R3: command count actual %0d expected at least 20", q_ops.size());
      end
      finish_run();
   end

endmodule